// File: doc/BRIEF.md
# SPI NOR Flash Command Front-End

This block sits behind the single-bit serial pins of a NOR flash device and interprets the commands a host sends. It reads the bus with the device clock, accepting clock polarity idle-low or idle-high with data sampled on the rising serial clock, most significant bit first. It collects the opcode, a 24-bit address and a leading data byte. When chip select is released, it decides whether the frame was well formed and may be acted on.

The block owns status register 1. Bit 0 is the busy flag, bit 1 is the write-enable latch, and bits 7:2 are stored bits that the host may write. Program and erase commands go to the array stub as a one-cycle request with an operation code and an address. A per-operation cycle timer then holds the busy flag. While the timer runs, only status reads are served. Every state-changing command needs the latch set beforehand, and the latch drops by itself when the timed operation ends.

Top module: `snor_cmd_front`

## Requirements
- R1: After reset, status register 1 reads 00h, `miso` is 0 and `mem_req` is 0.
- R2: Both serial clock idle levels are accepted. MOSI is sampled on rising SCLK and MISO changes after falling SCLK, most significant bit first.
- R3: Opcode 05h returns status register 1 in every byte after the opcode until chip select rises: bit 0 busy, bit 1 write-enable latch, bits 7:2 stored bits. Each byte shows the value current at its start.
- R4: A one-byte frame 06h sets the write-enable latch and a one-byte frame 04h clears it.
- R5: A program or erase frame received while the latch is 0 produces no request and leaves busy at 0.
- R6: An accepted operation pulses `mem_req` for one cycle two cycles after chip select rises. The op codes are 0 for program (02h, at least 5 bytes), 1 for sector erase (20h, exactly 4 bytes), 2 for block erase (52h, exactly 4 bytes) and 3 for chip erase (60h, exactly 1 byte, address 0). The 24-bit address is taken from bytes 1 to 3, first byte most significant.
- R7: While busy is 1, every frame other than a status read is ignored, latch commands included.
- R8: The latch returns to 0 on the same cycle that busy returns to 0 after an operation.
- R9: A status write (01h, 31h or 11h, at least 2 bytes, latch set) starts the status-write timer. Only 01h stores bits 7:2 of byte 1 into status bits 7:2, visible from acceptance.
- R10: A frame that ends with a partial byte, or whose byte count differs from the count its opcode requires, has no effect.
- R11: Busy stays 1 for exactly PROG_CYC, SECT_CYC, BLK_CYC, CHIP_CYC or WRSR_CYC clock cycles, counted from the acceptance cycle, for the matching operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, faster than four times SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 while deselected |
| mem_req | output | 1 | One-cycle operation request to the array stub |
| mem_op | output | 2 | Operation code for the request |
| mem_addr | output | 24 | Target address for the request |

## Verification
The hardest situation to reach is a status byte whose start falls near the cycle where the timer expires. That byte must show busy and the latch dropping together, and the byte before it must still show both set. The bench holds long status reads of several bytes across whole operation windows in both clock modes. Its own cycle model predicts the register at the exact cycle each byte is loaded, so every byte, including the one at the transition, is compared. Commands sent inside busy windows, frames with partial bytes and frames of the wrong length then show through later status reads and through the absence of requests.

// File: rtl/snor_cmd_front.sv
module snor_cmd_front #(
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 4000,
  parameter int BLK_CYC  = 8000,
  parameter int CHIP_CYC = 16000,
  parameter int WRSR_CYC = 1000,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic        miso,
  output logic        mem_req,
  output logic [1:0]  mem_op,
  output logic [23:0] mem_addr
);

  logic cs_s, cs_d, sclk_s, sclk_d, mosi_s;
  logic [2:0] bit_cnt, byte_cnt;
  logic [7:0] rx, opc, wdat, tx;
  logic [23:0] addr;
  logic wel;
  logic [5:0] sr_hi;
  logic [CNT_W-1:0] tmr, cyc;
  logic go_mem, go_sr, set_wel, clr_wel;
  logic [1:0] op;

  wire busy      = tmr != '0;
  wire sclk_rise = ~cs_s & sclk_s & ~sclk_d;
  wire sclk_fall = ~cs_s & ~sclk_s & sclk_d;
  wire cs_rise   = cs_s & ~cs_d;
  wire cs_fall   = ~cs_s & cs_d;
  wire [7:0] rx_next = {rx[6:0], mosi_s};
  wire [7:0] status  = {sr_hi, wel, busy};
  wire frame_ok  = cs_rise && bit_cnt == 3'd0 && byte_cnt != 3'd0 && !busy;

  assign miso = ~cs_s & tx[7];

  always_comb begin
    go_mem = 1'b0; go_sr = 1'b0; set_wel = 1'b0; clr_wel = 1'b0;
    op = 2'd0; cyc = '0;
    case (opc)
      8'h06: set_wel = frame_ok && byte_cnt == 3'd1;
      8'h04: clr_wel = frame_ok && byte_cnt == 3'd1;
      8'h02: begin go_mem = frame_ok && wel && byte_cnt >= 3'd5; op = 2'd0; cyc = CNT_W'(PROG_CYC); end
      8'h20: begin go_mem = frame_ok && wel && byte_cnt == 3'd4; op = 2'd1; cyc = CNT_W'(SECT_CYC); end
      8'h52: begin go_mem = frame_ok && wel && byte_cnt == 3'd4; op = 2'd2; cyc = CNT_W'(BLK_CYC); end
      8'h60: begin go_mem = frame_ok && wel && byte_cnt == 3'd1; op = 2'd3; cyc = CNT_W'(CHIP_CYC); end
      8'h01, 8'h31, 8'h11: begin go_sr = frame_ok && wel && byte_cnt >= 3'd2; cyc = CNT_W'(WRSR_CYC); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_s <= 1'b1; cs_d <= 1'b1; sclk_s <= 1'b0; sclk_d <= 1'b0; mosi_s <= 1'b0;
      bit_cnt <= '0; byte_cnt <= '0; rx <= '0; opc <= '0; wdat <= '0; addr <= '0; tx <= '0;
    end else begin
      cs_s <= cs_n; cs_d <= cs_s; sclk_s <= sclk; sclk_d <= sclk_s; mosi_s <= mosi;
      if (cs_fall) begin
        bit_cnt <= '0; byte_cnt <= '0; tx <= '0;
      end else begin
        if (sclk_rise) begin
          rx <= rx_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
            if (byte_cnt == 3'd0) opc <= rx_next;
            if (byte_cnt == 3'd1) wdat <= rx_next;
            if (byte_cnt >= 3'd1 && byte_cnt <= 3'd3) addr <= {addr[15:0], rx_next};
          end
        end
        if (sclk_fall)
          tx <= (bit_cnt == 3'd0 && byte_cnt != 3'd0 && opc == 8'h05) ? status : {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0; sr_hi <= '0; tmr <= '0;
      mem_req <= 1'b0; mem_op <= '0; mem_addr <= '0;
    end else begin
      mem_req <= go_mem;
      if (go_mem) begin
        mem_op   <= op;
        mem_addr <= (op == 2'd3) ? 24'd0 : addr;
      end
      if (go_mem || go_sr) tmr <= cyc;
      else if (busy) tmr <= tmr - 1'b1;
      if (set_wel) wel <= 1'b1;
      else if (clr_wel || tmr == CNT_W'(1)) wel <= 1'b0;
      if (go_sr && opc == 8'h01) sr_hi <= wdat[7:2];
    end
  end

  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(wel)); // R5
  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !$past(busy)); // R7
  AST_WEL_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy)); // R7
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R6
  AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && $rose(busy)); // R11

endmodule

// File: tb/sim_snor_cmd_front.sv
`timescale 1ns/1ps
module sim_snor_cmd_front;
  localparam int HALF = 4;
  localparam int P_PROG = 300, P_SECT = 400, P_BLK = 500, P_CHIP = 700, P_WRSR = 250;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, mem_req;
  logic [1:0] mem_op;
  logic [23:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  snor_cmd_front #(.PROG_CYC(P_PROG), .SECT_CYC(P_SECT), .BLK_CYC(P_BLK),
                   .CHIP_CYC(P_CHIP), .WRSR_CYC(P_WRSR), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr));

  int exp_cnt = 0;
  bit exp_wel = 1'b0, exp_req = 1'b0;
  logic [5:0] exp_sr = '0;
  logic [1:0] exp_op = '0;
  logic [23:0] exp_addr = '0;

  bit pend = 1'b0, p_whole = 1'b0;
  int p_nb = 0;
  logic [7:0] p_opc = '0, p_d1 = '0;
  logic [23:0] p_addr = '0;

  function automatic logic [7:0] exp_status();
    return {exp_sr, exp_wel, exp_cnt != 0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_cnt <= 0; exp_wel <= 1'b0; exp_req <= 1'b0; exp_sr <= '0;
    end else begin
      exp_req <= 1'b0;
      if (exp_cnt != 0) begin
        exp_cnt <= exp_cnt - 1;
        if (exp_cnt == 1) exp_wel <= 1'b0;
      end
      if (pend && p_whole && p_nb > 0 && exp_cnt == 0) begin
        case (p_opc)
          8'h06: if (p_nb == 1) exp_wel <= 1'b1;
          8'h04: if (p_nb == 1) exp_wel <= 1'b0;
          8'h02: if (p_nb >= 5 && exp_wel) begin exp_req <= 1'b1; exp_op <= 2'd0; exp_addr <= p_addr; exp_cnt <= P_PROG; end
          8'h20: if (p_nb == 4 && exp_wel) begin exp_req <= 1'b1; exp_op <= 2'd1; exp_addr <= p_addr; exp_cnt <= P_SECT; end
          8'h52: if (p_nb == 4 && exp_wel) begin exp_req <= 1'b1; exp_op <= 2'd2; exp_addr <= p_addr; exp_cnt <= P_BLK; end
          8'h60: if (p_nb == 1 && exp_wel) begin exp_req <= 1'b1; exp_op <= 2'd3; exp_addr <= 24'd0; exp_cnt <= P_CHIP; end
          8'h01: if (p_nb >= 2 && exp_wel) begin exp_sr <= p_d1[7:2]; exp_cnt <= P_WRSR; end
          8'h31, 8'h11: if (p_nb >= 2 && exp_wel) exp_cnt <= P_WRSR;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (mem_req !== exp_req || (exp_req && (mem_op !== exp_op || mem_addr !== exp_addr))) begin
        errors++;
        $display("FAIL R6 request: got req=%0b op=%0d addr=%h expected req=%0b op=%0d addr=%h",
                 mem_req, mem_op, mem_addr, exp_req, exp_op, exp_addr);
      end
    end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] expv, input string req, input string what);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
    end
  endtask

  task automatic frame(input bit m3, input logic [7:0] b[$], input int extra, input string req);
    int nb;
    logic [7:0] got, expv;
    nb = b.size();
    got = '0; expv = '0;
    sclk = m3;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      for (int i = 7; i >= 0; i--) begin
        sclk = 1'b0; mosi = b[k][i];
        @(negedge clk);
        if (i == 7 && k > 0) expv = exp_status();
        repeat (HALF - 1) @(negedge clk);
        got[i] = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      if (k > 0 && b[0] == 8'h05) chk(got, expv, req, "status byte");
    end
    for (int i = 0; i < extra; i++) begin
      sclk = 1'b0; mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!m3) sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    p_opc = (nb > 0) ? b[0] : 8'h00;
    p_nb = nb;
    p_whole = (extra == 0);
    p_d1 = (nb > 1) ? b[1] : 8'h00;
    p_addr = (nb > 3) ? {b[1], b[2], b[3]} : 24'd0;
    @(negedge clk); pend = 1'b1;
    @(negedge clk); pend = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic rd(input bit m3, input int n, input string req);
    logic [7:0] q[$];
    q.push_back(8'h05);
    for (int i = 0; i < n; i++) q.push_back(8'h00);
    frame(m3, q, 0, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({7'd0, miso}, 8'h00, "R1", "miso in reset");
    chk({7'd0, mem_req}, 8'h00, "R1", "mem_req in reset");
    rst_n = 1'b1;
    idle(4);
    rd(1'b0, 2, "R1");

    frame(1'b0, '{8'h02, 8'h00, 8'h10, 8'h00, 8'hAA}, 0, "R5");
    rd(1'b0, 1, "R5");
    frame(1'b1, '{8'h20, 8'h00, 8'h20, 8'h00}, 0, "R5");
    rd(1'b1, 1, "R5");

    frame(1'b1, '{8'h06}, 0, "R4");
    rd(1'b1, 2, "R4");
    frame(1'b0, '{8'h04}, 0, "R4");
    rd(1'b0, 1, "R4");

    frame(1'b0, '{8'h06}, 0, "R6");
    frame(1'b0, '{8'h20, 8'h12, 8'h34, 8'h56}, 0, "R6");
    rd(1'b1, 3, "R11");
    frame(1'b0, '{8'h04}, 0, "R7");
    frame(1'b1, '{8'h02, 8'h00, 8'h00, 8'h00, 8'h01}, 0, "R7");
    rd(1'b0, 3, "R7");
    idle(P_SECT);
    rd(1'b0, 1, "R8");

    frame(1'b0, '{8'h06}, 0, "R6");
    frame(1'b1, '{8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h11, 8'h22}, 0, "R6");
    rd(1'b1, 6, "R3");
    idle(P_PROG);
    rd(1'b0, 1, "R8");

    frame(1'b1, '{8'h06}, 0, "R6");
    frame(1'b0, '{8'h52, 8'h00, 8'hFF, 8'h00}, 0, "R6");
    frame(1'b0, '{8'h60}, 0, "R7");
    rd(1'b0, 7, "R11");
    idle(P_BLK);
    frame(1'b0, '{8'h06}, 0, "R6");
    frame(1'b1, '{8'h60}, 0, "R6");
    rd(1'b1, 4, "R2");
    idle(P_CHIP);
    rd(1'b1, 1, "R8");

    frame(1'b0, '{8'h06}, 3, "R10");
    rd(1'b0, 1, "R10");
    frame(1'b1, '{8'h06}, 0, "R10");
    frame(1'b1, '{8'h20, 8'h00, 8'h00, 8'h10, 8'h55}, 0, "R10");
    frame(1'b0, '{8'h20, 8'h00, 8'h00}, 0, "R10");
    frame(1'b0, '{8'h20, 8'h00, 8'h40, 8'h00}, 5, "R10");
    rd(1'b0, 1, "R10");
    frame(1'b0, '{8'h04}, 0, "R10");

    frame(1'b0, '{8'h06}, 0, "R9");
    frame(1'b0, '{8'h01, 8'hFC}, 0, "R9");
    rd(1'b0, 1, "R9");
    idle(P_WRSR);
    rd(1'b1, 1, "R9");
    frame(1'b1, '{8'h06}, 0, "R9");
    frame(1'b1, '{8'h31, 8'h00}, 0, "R9");
    rd(1'b1, 1, "R9");
    idle(P_WRSR);
    frame(1'b0, '{8'h06}, 0, "R9");
    frame(1'b0, '{8'h11, 8'h00}, 0, "R9");
    idle(P_WRSR);
    rd(1'b0, 1, "R9");
    frame(1'b0, '{8'h01, 8'h00}, 0, "R9");
    rd(1'b1, 2, "R9");

    idle(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule